// File: doc/BRIEF.md
# Burst-Filled Shadow Register Bank

This block holds a set of timer configuration values (a period and several compare values) as pairs of shadow and active registers. A DMA engine fills them through a single burst-access port. When a compare-1 event arrives and no burst is running, the block raises a DMA request. Each accepted data word is sent to the next register selected by a burst-enable mask, in ascending index order. A one-clock done pulse marks the acceptance of the last word.

A preload-enable bit decides where words land. With preload off, each word goes straight into the active register. With preload on, words only fill the shadow copies. The shadow values are then copied into the active registers at a point picked by a four-bit gating code:

- on the counter rollover event,
- on the burst-done pulse, or
- on the first repetition event after the burst ends, when the repetition-update enable is set.

A plain register write port follows the same preload rule.

Top module: `burst_shadow_update`

## Requirements
- R1: A synchronous active-high reset clears every shadow and active register to zero, drops the DMA request and the done pulse, and empties the burst word pointer.
- R2: A compare-1 event raises `dma_req` in the next cycle only if no burst is in progress and the mask is non-zero. The request stays high until the first `dma_ack`. A compare-1 event during a burst is ignored.
- R3: Each `dma_ack` during a burst writes `dma_wdata` to the lowest-index enabled register not yet written in this burst. Register index 0 is the period and indices 1 upward are compares 1, 2 and 3. An `dma_ack` outside a burst writes nothing.
- R4: `burst_done` is high for exactly one clock, in the cycle after the word for the last enabled register is accepted.
- R5: With `preload_en`=0, a written word appears on that register's `act_regs` slice in the cycle after the write.
- R6: With `preload_en`=1, words go only to shadow copies, and `act_regs` holds its value except in a cycle following a commit.
- R7: With `gate_sel`=4'b0001, all shadow values are copied to the active registers at the clock edge that ends the `burst_done` cycle.
- R8: With `gate_sel`=4'b0010 and `rep_upd_en`=1, the copy takes place on the first `rep_evt` strictly after the `burst_done` cycle. With `rep_upd_en`=0, `rep_evt` never copies.
- R9: Under `gate_sel`=4'b0010, a `rep_evt` in the same cycle as `burst_done` does not copy. The copy waits for the next `rep_evt`.
- R10: With `gate_sel`=4'b0000, the copy happens on `roll_evt`, regardless of any burst. Other gating codes never copy.
- R11: `reg_we` writes `reg_wdata` to register `reg_idx` under the same preload rule. If a burst word targets the same register in the same cycle, the burst word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register-bus write strobe |
| reg_idx | input | IW | Register-bus target index |
| reg_wdata | input | DW | Register-bus write data |
| dma_req | output | 1 | DMA request for a burst |
| dma_ack | input | 1 | One burst word accepted this cycle |
| dma_wdata | input | DW | Burst data word |
| cmp1_evt | input | 1 | Compare-1 match strobe, starts a burst |
| rep_evt | input | 1 | Repetition event strobe |
| roll_evt | input | 1 | Counter rollover/reset strobe |
| burst_mask | input | NREG | Registers taking part in the burst |
| preload_en | input | 1 | Shadow buffering enable |
| gate_sel | input | 4 | Update gating code |
| rep_upd_en | input | 1 | Repetition-update enable |
| burst_done | output | 1 | One-clock pulse at burst end |
| act_regs | output | NREG*DW | Active register values, index 0 in the low bits |

## Verification
The two functions that can coincide are the end of a burst and a repetition event. The bench raises `rep_evt` in exactly the cycle where `burst_done` is high under gating code 0010. It then judges that the active registers stay unchanged and move only on the following repetition event.

A second collision tested is a register-bus write and a burst word aimed at the same index in one cycle, where the burst word must win. A cycle-accurate behavioural model compares every output on every clock, both in these directed cases and in a long random phase.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int unsigned GATE_W = 4;
  typedef enum logic [GATE_W-1:0] {
    GT_ROLL  = 4'b0000,
    GT_BURST = 4'b0001,
    GT_REP   = 4'b0010
  } gate_e;
endpackage

// File: rtl/bsu_burst_seq.sv
module bsu_burst_seq #(
  parameter int unsigned NREG = 4,
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp1_evt,
  input  logic            dma_ack,
  input  logic [NREG-1:0] burst_mask,
  output logic            dma_req,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic            done
);
  logic [NREG-1:0] rem, rem_nxt;
  logic            busy;

  // lowest pending target
  always_comb begin
    wr_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) wr_idx = IW'(i);
  end

  assign wr_en   = busy && dma_ack;
  assign rem_nxt = rem & ~(NREG'(1) << wr_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      busy    <= 1'b0;
      dma_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= wr_en && (rem_nxt == '0);
      if (wr_en) begin
        rem <= rem_nxt;
        if (rem_nxt == '0) busy <= 1'b0;
      end
      if (dma_req && dma_ack) dma_req <= 1'b0;
      if (cmp1_evt && !busy && (|burst_mask)) begin
        dma_req <= 1'b1;
        busy    <= 1'b1;
        rem     <= burst_mask;
      end
    end
  end
endmodule

// File: rtl/bsu_update_ctl.sv
module bsu_update_ctl
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              preload_en,
  input  logic [GATE_W-1:0] gate_sel,
  input  logic              rep_upd_en,
  input  logic              rep_evt,
  input  logic              roll_evt,
  input  logic              done,
  output logic              commit
);
  logic pend, rep_hit, rep_mode;

  assign rep_mode = (gate_sel == GT_REP) && rep_upd_en;
  assign rep_hit  = rep_mode && pend && rep_evt && !done;

  always_comb begin
    commit = 1'b0;
    if (preload_en) begin
      unique case (gate_sel)
        GT_ROLL:  commit = roll_evt;
        GT_BURST: commit = done;
        GT_REP:   commit = rep_hit;
        default:  commit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   pend <= 1'b0;
    else if (done && rep_mode) pend <= 1'b1;
    else if (rep_hit)          pend <= 1'b0;
  end
endmodule

// File: rtl/bsu_shadow_bank.sv
module bsu_shadow_bank #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 16,
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preload_en,
  input  logic             commit,
  input  logic             dma_we,
  input  logic [IW-1:0]    dma_idx,
  input  logic [DW-1:0]    dma_d,
  input  logic             bus_we,
  input  logic [IW-1:0]    bus_idx,
  input  logic [DW-1:0]    bus_d,
  output logic [NREG*DW-1:0] act
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] sh, ac;
    logic          hit_d, hit_b;
    assign hit_d = dma_we && (32'(dma_idx) == g);
    assign hit_b = bus_we && (32'(bus_idx) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= '0;
        ac <= '0;
      end else begin
        if (commit) ac <= sh;
        if (hit_d || hit_b) begin
          sh <= hit_d ? dma_d : bus_d;
          if (!preload_en) ac <= hit_d ? dma_d : bus_d;
        end
      end
    end
    assign act[g*DW +: DW] = ac;
  end
endmodule

// File: rtl/burst_shadow_update.sv
module burst_shadow_update
  import bsu_pkg::*;
#(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 16,
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IW-1:0]     reg_idx,
  input  logic [DW-1:0]     reg_wdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic [DW-1:0]     dma_wdata,
  input  logic              cmp1_evt,
  input  logic              rep_evt,
  input  logic              roll_evt,
  input  logic [NREG-1:0]   burst_mask,
  input  logic              preload_en,
  input  logic [GATE_W-1:0] gate_sel,
  input  logic              rep_upd_en,
  output logic              burst_done,
  output logic [NREG*DW-1:0] act_regs
);
  logic          wr_en, commit_w;
  logic [IW-1:0] wr_idx;

  bsu_burst_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst(rst), .cmp1_evt(cmp1_evt), .dma_ack(dma_ack),
    .burst_mask(burst_mask), .dma_req(dma_req), .wr_en(wr_en),
    .wr_idx(wr_idx), .done(burst_done)
  );

  bsu_update_ctl u_ctl (
    .clk(clk), .rst(rst), .preload_en(preload_en), .gate_sel(gate_sel),
    .rep_upd_en(rep_upd_en), .rep_evt(rep_evt), .roll_evt(roll_evt),
    .done(burst_done), .commit(commit_w)
  );

  bsu_shadow_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .preload_en(preload_en), .commit(commit_w),
    .dma_we(wr_en), .dma_idx(wr_idx), .dma_d(dma_wdata),
    .bus_we(reg_we), .bus_idx(reg_idx), .bus_d(reg_wdata),
    .act(act_regs)
  );
endmodule

// File: rtl/burst_shadow_update_chk.sv
module burst_shadow_update_chk #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              preload_en,
  input logic [3:0]        gate_sel,
  input logic              burst_done,
  input logic              commit_w,
  input logic [NREG*DW-1:0] act_regs
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (act_regs == '0) && !dma_req && !burst_done);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req && !dma_ack |=> dma_req);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);
  // R6
  preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    preload_en && !commit_w |=> $stable(act_regs));
  // R7
  gate_burst_chk: assert property (@(posedge clk) disable iff (rst)
    preload_en && gate_sel == 4'b0001 && burst_done |-> commit_w);
  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    gate_sel == 4'b0010 && burst_done |-> !commit_w);
endmodule

bind burst_shadow_update burst_shadow_update_chk #(.NREG(NREG), .DW(DW)) u_chk (.*);

// File: tb/sim_burst_shadow_update.sv
module sim_burst_shadow_update;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int IW   = 2;

  logic clk = 0, rst = 1;
  logic reg_we = 0, dma_ack = 0, cmp1_evt = 0, rep_evt = 0, roll_evt = 0;
  logic preload_en = 0, rep_upd_en = 0;
  logic [IW-1:0] reg_idx = 0;
  logic [DW-1:0] reg_wdata = 0, dma_wdata = 0;
  logic [NREG-1:0] burst_mask = 0;
  logic [3:0] gate_sel = 0;
  logic dma_req, burst_done;
  logic [NREG*DW-1:0] act_regs;

  always #2 clk = ~clk;

  burst_shadow_update #(.NREG(NREG), .DW(DW)) u0 (.*);

  // behavioural reference model
  int q[$];
  logic [DW-1:0] sh[NREG], ac[NREG];
  logic m_req, m_busy, m_done, m_pend;

  task automatic mwr(int i, logic [DW-1:0] d);
    sh[i] = d;
    if (!preload_en) ac[i] = d;
  endtask

  always @(posedge clk) begin
    logic cr, cm, bo, dw, np;
    int di;
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin sh[i] = 0; ac[i] = 0; end
      q.delete(); m_req = 0; m_busy = 0; m_done = 0; m_pend = 0;
    end else begin
      bo = m_busy; dw = 0; di = -1;
      cr = gate_sel == 2 && rep_upd_en && m_pend && rep_evt && !m_done;
      cm = preload_en && ((gate_sel == 0 && roll_evt) || (gate_sel == 1 && m_done) || cr);
      np = (m_done && gate_sel == 2 && rep_upd_en) ? 1'b1 : (cr ? 1'b0 : m_pend);
      if (cm) for (int i = 0; i < NREG; i++) ac[i] = sh[i];
      m_done = 0;
      if (bo && dma_ack) begin
        di = q.pop_front(); dw = 1; mwr(di, dma_wdata);
        if (q.size() == 0) begin m_done = 1; m_busy = 0; end
      end
      if (reg_we && !(dw && di == int'(reg_idx))) mwr(int'(reg_idx), reg_wdata);
      if (m_req && dma_ack) m_req = 0;
      if (cmp1_evt && !bo && burst_mask != 0) begin
        m_req = 1; m_busy = 1; q.delete();
        for (int i = 0; i < NREG; i++) if (burst_mask[i]) q.push_back(i);
      end
      m_pend = np;
    end
  end

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit over = 0;

  task automatic compare();
    logic [NREG*DW-1:0] exp;
    for (int i = 0; i < NREG; i++) exp[i*DW +: DW] = ac[i];
    n_chk++;
    if (act_regs !== exp || dma_req !== m_req || burst_done !== m_done) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h req=%b/%b done=%b/%b", phase,
               act_regs, exp, dma_req, m_req, burst_done, m_done);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    reg_we = 0; dma_ack = 0; cmp1_evt = 0; rep_evt = 0; roll_evt = 0;
  endtask

  task automatic burst(logic [NREG-1:0] m, logic [DW-1:0] base, int gap, bit rep_at_done);
    burst_mask = m; cmp1_evt = 1; tick();
    for (int k = 0; k < $countones(m); k++) begin
      for (int g = 0; g < gap; g++) tick();
      dma_ack = 1; dma_wdata = base + DW'(k); tick();
    end
    if (rep_at_done) rep_evt = 1;
    tick(); tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    phase = "R5"; preload_en = 0; burst(4'b1011, 16'h1100, 0, 0);
    phase = "R3"; dma_ack = 1; dma_wdata = 16'hdead; tick(); tick();
    burst(4'b0100, 16'h3300, 1, 0);
    phase = "R2"; burst_mask = 4'b1111; cmp1_evt = 1; tick(); tick();
    cmp1_evt = 1; tick(); dma_ack = 1; dma_wdata = 16'h0a0a; tick();
    for (int k = 0; k < 3; k++) begin dma_ack = 1; dma_wdata = 16'h0b00 + 16'(k); tick(); end
    tick();
    phase = "R2"; burst_mask = 0; cmp1_evt = 1; tick(); tick();
    phase = "R7"; preload_en = 1; gate_sel = 1; burst(4'b0110, 16'h7700, 2, 0);
    phase = "R6"; gate_sel = 4'b0101; burst(4'b1111, 16'h6600, 0, 0);
    roll_evt = 1; rep_evt = 1; tick(); tick();
    phase = "R8"; gate_sel = 2; rep_upd_en = 1; burst(4'b1001, 16'h8800, 0, 0);
    repeat (3) tick(); rep_evt = 1; tick(); tick(); rep_evt = 1; tick(); tick();
    rep_upd_en = 0; burst(4'b0011, 16'h8a00, 0, 0); rep_evt = 1; tick(); tick();
    phase = "R9"; rep_upd_en = 1; burst(4'b1100, 16'h9900, 0, 1);
    tick(); rep_evt = 1; tick(); tick();
    phase = "R10"; gate_sel = 0; burst(4'b1111, 16'ha000, 0, 0);
    tick(); roll_evt = 1; tick(); tick();
    phase = "R11"; reg_we = 1; reg_idx = 2; reg_wdata = 16'hb0b0; tick(); roll_evt = 1; tick();
    preload_en = 0; reg_we = 1; reg_idx = 1; reg_wdata = 16'hc1c1; tick(); tick();
    burst_mask = 4'b0001; cmp1_evt = 1; tick();
    dma_ack = 1; dma_wdata = 16'hd0d0; reg_we = 1; reg_idx = 0; reg_wdata = 16'he0e0; tick(); tick();
    phase = "R1"; rst = 1; tick(); rst = 0; tick();
    phase = "RND";
    for (int n = 0; n < 3000; n++) begin
      reg_we = ($urandom % 8) == 0; reg_idx = IW'($urandom); reg_wdata = DW'($urandom);
      dma_ack = $urandom % 2; dma_wdata = DW'($urandom);
      cmp1_evt = ($urandom % 6) == 0; rep_evt = ($urandom % 4) == 0; roll_evt = ($urandom % 9) == 0;
      burst_mask = NREG'($urandom);
      if ($urandom % 50 == 0) begin
        preload_en = $urandom % 4 != 0; gate_sel = 4'($urandom % 4); rep_upd_en = $urandom % 3 != 0;
      end
      tick();
    end
    if (!over) begin
      over = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!over) begin
      over = 1; n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule